// File: doc/BRIEF.md
# Dual-Clock Pixel FIFO with Burst Flags

This block carries 16-bit video words from a pixel write clock domain to an independent read clock domain. Each stored word also has a one-bit tag that marks it as either a pixel word or a control-code word. Both kinds of word count equally toward the fill level. The FIFO holds up to 40 words. The write pointer and the read pointer are binary counters. Each one crosses into the other clock domain as gray code through a two-flop synchronizer, and each domain computes its own fill level from its local pointer and the synchronized remote pointer.

Three status outputs are produced in the read domain:
- **Burst-ready** tells a downstream reader when to begin draining in a burst. It has hysteresis: it rises at a fill threshold and stays up until the FIFO is completely empty.
- **Almost-empty** is registered. A reader should stop as soon as it sees this flag.
- **Almost-full** has a threshold that can be switched between two levels.

The burst-ready and almost-full outputs each have their own polarity-invert input. A single active-low asynchronous reset clears both pointers, the synchronizers and the flag state. Writes that arrive when the FIFO is full are discarded and recorded in a sticky overflow bit.

Top module: `pixfifo_dc`

## Requirements
- R1: While `rst_n` is low, both pointers and all flag state are cleared. After reset `rd_empty`=1, `wr_full`=0, `wr_overflow`=0 and `alm_empty`=1. The raw burst and almost-full states are 0, so `burst_rdy`=`burst_inv` and `alm_full`=`afull_inv`.
- R2: Words leave the FIFO in the order they were written. The 16-bit data and the tag bit (1 = control code, 0 = pixel) are both preserved. `rd_data`/`rd_tag` update on the `rd_clk` edge that accepts a read.
- R3: When 40 words are stored, `wr_full`=1. A write presented while full is dropped, leaves the stored contents unchanged and sets `wr_overflow`. `wr_overflow` stays set until reset.
- R4: A read request while `rd_empty`=1 does not move the read pointer, and `rd_data`/`rd_tag` keep the last word read.
- R5: The raw burst state rises when the read-side fill level reaches 20 (with `cfg_burst_hi`=0) or reaches 32 (with `cfg_burst_hi`=1).
- R6: Once risen, the raw burst state stays high at every nonzero fill level, including levels below the rising threshold. It falls only when the fill level is 0.
- R7: `alm_empty` is 1 when the read-side fill level is below 9 and 0 when it is 9 or more. It is registered one `rd_clk` after the fill level.
- R8: The raw almost-full state is 1 when the fill level is above 32 (with `cfg_af_half`=0) or is 20 or more (with `cfg_af_half`=1).
- R9: `burst_rdy` equals the raw burst state XOR `burst_inv`, and `alm_full` equals the raw almost-full state XOR `afull_inv`. A 0 on either invert input means active-high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side pixel clock |
| rd_clk | input | 1 | Read-side clock, asynchronous to wr_clk |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| wr_en | input | 1 | Write request |
| wr_data | input | 16 | Word to store |
| wr_tag | input | 1 | 1 = control-code word, 0 = pixel word |
| wr_full | output | 1 | FIFO holds 40 words (write domain) |
| wr_overflow | output | 1 | Sticky: a write was dropped while full |
| rd_en | input | 1 | Read request |
| rd_data | output | 16 | Last word read |
| rd_tag | output | 1 | Tag of the last word read |
| rd_empty | output | 1 | No word available (read domain) |
| cfg_burst_hi | input | 1 | Burst rising threshold: 0 = 20, 1 = 32 |
| cfg_af_half | input | 1 | Almost-full level: 0 = above 32, 1 = 20 or more |
| burst_inv | input | 1 | Invert burst_rdy |
| afull_inv | input | 1 | Invert alm_full |
| burst_rdy | output | 1 | Burst-ready with hysteresis |
| alm_empty | output | 1 | Fewer than 9 words stored |
| alm_full | output | 1 | Almost-full flag |

## Verification
A write becomes visible on the read side after one `wr_clk` edge for the pointer, two `rd_clk` edges in the synchronizer, and one more `rd_clk` edge for the registered flags. That is roughly four read cycles. A read result appears on the `rd_clk` edge that accepts it. For these reasons the bench never checks a flag directly after a write. It stops all traffic, waits ten read cycles for the level to settle, and only then compares the three flags against the word count it tracks itself. Read data is handled by a monitor, which pops the scoreboard queue on the falling edge that follows each accepted read.

// File: rtl/pixfifo_pkg.sv
package pixfifo_pkg;
  localparam int DATA_W = 16;
  localparam int PTR_W  = 6;

  typedef logic [PTR_W-1:0] ptr_t;

  typedef struct packed {
    logic              tag;
    logic [DATA_W-1:0] data;
  } word_t;

  function automatic ptr_t bin2gray(ptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr_t gray2bin(ptr_t g);
    ptr_t b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // Occupancy seen from one side: leading pointer minus trailing pointer, modulo 2**PTR_W.
  function automatic ptr_t level_of(ptr_t lead, ptr_t trail);
    return lead - trail;
  endfunction
endpackage

// File: rtl/pixfifo_sync.sv
module pixfifo_sync #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/pixfifo_mem.sv
module pixfifo_mem #(
  parameter int W  = 17,
  parameter int AW = 6
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int ENTRIES = 1 << AW;

  logic [W-1:0] store [ENTRIES];

  always_ff @(posedge wr_clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/pixfifo_flags.sv
module pixfifo_flags #(
  parameter int PW        = 6,
  parameter int AE_BELOW  = 9,
  parameter int BURST_LO  = 20,
  parameter int BURST_HI  = 32,
  parameter int AF_ABOVE  = 32,
  parameter int AF_HALF   = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] level,
  input  logic          cfg_burst_hi,
  input  logic          cfg_af_half,
  input  logic          burst_inv,
  input  logic          afull_inv,
  output logic          burst_q,
  output logic          afull_q,
  output logic          burst_rdy,
  output logic          alm_empty,
  output logic          alm_full
);
  logic [PW-1:0] burst_thr;
  logic          burst_next;
  logic          afull_next;

  assign burst_thr = cfg_burst_hi ? PW'(BURST_HI) : PW'(BURST_LO);

  always_comb begin
    if (level == '0)              burst_next = 1'b0;
    else if (level >= burst_thr)  burst_next = 1'b1;
    else                          burst_next = burst_q;
  end

  assign afull_next = cfg_af_half ? (level >= PW'(AF_HALF)) : (level > PW'(AF_ABOVE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_q   <= 1'b0;
      afull_q   <= 1'b0;
      alm_empty <= 1'b1;
    end else begin
      burst_q   <= burst_next;
      afull_q   <= afull_next;
      alm_empty <= level < PW'(AE_BELOW);
    end
  end

  assign burst_rdy = burst_q ^ burst_inv;
  assign alm_full  = afull_q ^ afull_inv;
endmodule

// File: rtl/pixfifo_dc.sv
module pixfifo_dc
  import pixfifo_pkg::*;
#(
  parameter int DEPTH    = 40,
  parameter int AE_BELOW = 9,
  parameter int BURST_LO = 20,
  parameter int BURST_HI = 32,
  parameter int AF_ABOVE = 32,
  parameter int AF_HALF  = 20
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_tag,
  output logic              wr_full,
  output logic              wr_overflow,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_tag,
  output logic              rd_empty,
  input  logic              cfg_burst_hi,
  input  logic              cfg_af_half,
  input  logic              burst_inv,
  input  logic              afull_inv,
  output logic              burst_rdy,
  output logic              alm_empty,
  output logic              alm_full
);
  localparam int WORD_W = DATA_W + 1;

  // ---------------- write domain ----------------
  ptr_t  wbin, wgray, rgray_w;
  ptr_t  wr_level;
  logic  wr_accept;
  word_t wr_word;

  assign wr_level  = level_of(wbin, gray2bin(rgray_w));
  assign wr_full   = wr_level >= ptr_t'(DEPTH);
  assign wr_accept = wr_en && !wr_full;
  assign wr_word   = '{tag: wr_tag, data: wr_data};

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin        <= '0;
      wgray       <= '0;
      wr_overflow <= 1'b0;
    end else begin
      if (wr_accept) begin
        wbin  <= wbin + 1'b1;
        wgray <= bin2gray(wbin + 1'b1);
      end
      if (wr_en && wr_full) wr_overflow <= 1'b1;
    end
  end

  // ---------------- read domain ----------------
  ptr_t  rbin, rgray, wgray_r;
  ptr_t  rd_level;
  logic  rd_accept;
  word_t rd_word;

  assign rd_level  = level_of(gray2bin(wgray_r), rbin);
  assign rd_empty  = rd_level == '0;
  assign rd_accept = rd_en && !rd_empty;

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (rd_accept) begin
      rbin  <= rbin + 1'b1;
      rgray <= bin2gray(rbin + 1'b1);
    end
  end

  // ---------------- crossings ----------------
  pixfifo_sync #(.W(PTR_W)) sync_w2r_i (
    .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_r)
  );

  pixfifo_sync #(.W(PTR_W)) sync_r2w_i (
    .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_w)
  );

  // ---------------- storage ----------------
  logic [WORD_W-1:0] rdata_raw;

  pixfifo_mem #(.W(WORD_W), .AW(PTR_W)) mem_i (
    .wr_clk(wr_clk), .we(wr_accept), .waddr(wbin), .wdata(wr_word),
    .rd_clk(rd_clk), .rst_n(rst_n), .re(rd_accept), .raddr(rbin),
    .rdata(rdata_raw)
  );

  assign rd_word = word_t'(rdata_raw);
  assign rd_data = rd_word.data;
  assign rd_tag  = rd_word.tag;

  // ---------------- flags ----------------
  logic burst_q, afull_q;

  pixfifo_flags #(
    .PW(PTR_W), .AE_BELOW(AE_BELOW), .BURST_LO(BURST_LO), .BURST_HI(BURST_HI),
    .AF_ABOVE(AF_ABOVE), .AF_HALF(AF_HALF)
  ) flags_i (
    .clk(rd_clk), .rst_n(rst_n), .level(rd_level),
    .cfg_burst_hi(cfg_burst_hi), .cfg_af_half(cfg_af_half),
    .burst_inv(burst_inv), .afull_inv(afull_inv),
    .burst_q(burst_q), .afull_q(afull_q),
    .burst_rdy(burst_rdy), .alm_empty(alm_empty), .alm_full(alm_full)
  );

  initial begin
    if (DEPTH >= (1 << PTR_W)) $error("DEPTH must be below 2**PTR_W");
  end
endmodule

// File: rtl/pixfifo_dc_chk.sv
module pixfifo_dc_chk
  import pixfifo_pkg::*;
#(
  parameter int DEPTH = 40
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              rst_n,
  input logic              wr_full,
  input logic              wr_overflow,
  input ptr_t              wbin,
  input ptr_t              rd_level,
  input logic              rd_empty,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_tag,
  input logic              burst_q,
  input logic              alm_empty
);
  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_full |=> (wbin == $past(wbin))); // R3

  AST_OVERFLOW_STICKY: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_overflow |=> wr_overflow); // R3

  AST_LEVEL_BOUND: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_level <= ptr_t'(DEPTH)); // R3

  AST_EMPTY_READ_HOLD: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_empty |=> $stable({rd_tag, rd_data})); // R4

  AST_BURST_HOLD: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (burst_q && rd_level != '0) |=> burst_q); // R6

  AST_BURST_DROP: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_level == '0) |=> !burst_q); // R6

  AST_AE_CLEAR_WHEN_DEEP: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_level >= ptr_t'(DEPTH)) |=> !alm_empty); // R7
endmodule

bind pixfifo_dc pixfifo_dc_chk #(.DEPTH(DEPTH)) chk_i (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
  .wr_full(wr_full), .wr_overflow(wr_overflow), .wbin(wbin),
  .rd_level(rd_level), .rd_empty(rd_empty), .rd_data(rd_data), .rd_tag(rd_tag),
  .burst_q(burst_q), .alm_empty(alm_empty)
);

// File: tb/pixfifo_dc_tb_top.sv
`timescale 1ns/1ps
module pixfifo_dc_tb_top;
  localparam int CAP = 40;

  logic wr_clk = 0, rd_clk = 0, rst_n = 0;
  logic wr_en = 0, wr_tag = 0, rd_en = 0;
  logic [15:0] wr_data = '0;
  logic cfg_burst_hi = 0, cfg_af_half = 0, burst_inv = 0, afull_inv = 0;
  logic wr_full, wr_overflow, rd_tag, rd_empty, burst_rdy, alm_empty, alm_full;
  logic [15:0] rd_data;

  always #2 wr_clk = ~wr_clk;   // 250 MHz
  always #3 rd_clk = ~rd_clk;

  pixfifo_dc dut_i (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_data(wr_data), .wr_tag(wr_tag),
    .wr_full(wr_full), .wr_overflow(wr_overflow),
    .rd_en(rd_en), .rd_data(rd_data), .rd_tag(rd_tag), .rd_empty(rd_empty),
    .cfg_burst_hi(cfg_burst_hi), .cfg_af_half(cfg_af_half),
    .burst_inv(burst_inv), .afull_inv(afull_inv),
    .burst_rdy(burst_rdy), .alm_empty(alm_empty), .alm_full(alm_full)
  );

  int n_checks = 0, n_fail = 0;
  int model_cnt = 0;
  int seq = 0;
  logic [16:0] sb_q[$];
  logic [16:0] last_rd = '0;
  logic pend = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_words(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge wr_clk); #1;
      wr_en   = 1;
      wr_data = 16'hA000 + 16'(seq);
      wr_tag  = seq[0];
      if (model_cnt < CAP) begin
        sb_q.push_back({wr_tag, wr_data});
        model_cnt++;
      end
      seq++;
      @(posedge wr_clk); #1;
      wr_en = 0;
    end
  endtask

  task automatic pop_words(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge rd_clk); #1;
      rd_en = 1;
      @(posedge rd_clk); #1;
      rd_en = 0;
      @(posedge rd_clk); #1;
    end
  endtask

  task automatic settle();
    repeat (10) @(posedge rd_clk);
    repeat (2) @(posedge wr_clk);
    @(negedge rd_clk);
  endtask

  // Monitor: compares each accepted read with the scoreboard head (R2).
  always @(negedge rd_clk) begin
    if (pend) begin
      logic [16:0] exp_w;
      exp_w = sb_q.size() > 0 ? sb_q.pop_front() : 17'h0;
      model_cnt--;
      last_rd = exp_w;
      check({rd_tag, rd_data} === exp_w, "R2 read word", int'({rd_tag, rd_data}), int'(exp_w));
    end
    pend = rd_en && !rd_empty;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #15 rst_n = 1;
    @(negedge rd_clk);
    // R1 reset state
    check(rd_empty == 1,    "R1 rd_empty",    rd_empty, 1);
    check(wr_full == 0,     "R1 wr_full",     wr_full, 0);
    check(wr_overflow == 0, "R1 wr_overflow", wr_overflow, 0);
    check(alm_empty == 1,   "R1 alm_empty",   alm_empty, 1);
    check(burst_rdy == 0,   "R1 burst_rdy",   burst_rdy, 0);
    check(alm_full == 0,    "R1 alm_full",    alm_full, 0);

    push_words(8); settle();
    check(alm_empty == 1, "R7 level 8", alm_empty, 1);
    push_words(1); settle();
    check(alm_empty == 0, "R7 level 9", alm_empty, 0);
    push_words(10); settle();
    check(burst_rdy == 0, "R5 level 19 lo", burst_rdy, 0);
    check(alm_full == 0,  "R8 level 19", alm_full, 0);
    cfg_af_half = 1; settle();
    check(alm_full == 0,  "R8 half level 19", alm_full, 0);
    cfg_af_half = 0;
    push_words(1); settle();
    check(burst_rdy == 1, "R5 level 20 lo", burst_rdy, 1);
    check(rd_empty == 0,  "R2 not empty", rd_empty, 0);
    cfg_af_half = 1; settle();
    check(alm_full == 1,  "R8 half level 20", alm_full, 1);
    cfg_af_half = 0; settle();
    check(alm_full == 0,  "R8 level 20", alm_full, 0);
    burst_inv = 1; afull_inv = 1; settle();
    check(burst_rdy == 0, "R9 burst inverted", burst_rdy, 0);
    check(alm_full == 1,  "R9 afull inverted", alm_full, 1);
    burst_inv = 0; afull_inv = 0;

    pop_words(19); settle();
    check(burst_rdy == 1, "R6 hold at 1", burst_rdy, 1);
    check(alm_empty == 1, "R7 level 1", alm_empty, 1);
    pop_words(1); settle();
    check(burst_rdy == 0, "R6 drop at 0", burst_rdy, 0);
    check(rd_empty == 1,  "R4 empty", rd_empty, 1);

    // R4 read while empty
    @(posedge rd_clk); #1 rd_en = 1;
    @(posedge rd_clk); #1 rd_en = 0;
    settle();
    check({rd_tag, rd_data} === last_rd, "R4 data held", int'({rd_tag, rd_data}), int'(last_rd));
    check(rd_empty == 1, "R4 still empty", rd_empty, 1);

    cfg_burst_hi = 1;
    push_words(31); settle();
    check(burst_rdy == 0, "R5 level 31 hi", burst_rdy, 0);
    push_words(1); settle();
    check(burst_rdy == 1, "R5 level 32 hi", burst_rdy, 1);
    check(alm_full == 0,  "R8 level 32", alm_full, 0);
    push_words(1); settle();
    check(alm_full == 1,  "R8 level 33", alm_full, 1);

    push_words(12); settle();
    check(wr_full == 1,     "R3 full", wr_full, 1);
    check(wr_overflow == 1, "R3 overflow", wr_overflow, 1);
    check(sb_q.size() == CAP, "R3 model level", sb_q.size(), CAP);
    pop_words(CAP); settle();
    check(rd_empty == 1,    "R3 drained 40", rd_empty, 1);
    check(wr_overflow == 1, "R3 overflow sticky", wr_overflow, 1);
    check(wr_full == 0,     "R3 not full", wr_full, 0);
    check(burst_rdy == 0,   "R6 drop after drain", burst_rdy, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule